// File: doc/BRIEF.md
# USB IN Endpoint Transfer Controller

This block follows one device-side IN endpoint through a transfer at the token and handshake level. Software programs a transfer length in bytes, a packet count, a maximum packet size and an enable flag in one load strobe. It can also hold a level NAK request at any time. While software pushes packets into the transmit buffer (a separate block), the remaining byte count falls. Each IN token is answered with data, a zero-length packet or NAK. The remaining packet count falls only when the host acknowledges a data packet or a zero-length packet goes out.

The two counters are independent. A transfer completes, raising a one-cycle completion interrupt and dropping the enable, only when both have reached zero. A timeout leaves the packet in the buffer and the count untouched, so the next token retransmits it. An IN token that finds nothing to send and no packets left raises the empty-on-token interrupt. Remaining size, remaining packets, bytes sent and bytes still to send are available at all times for progress reporting.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset the endpoint is disabled, rem_size and rem_pkts are 0, tok_rsp is 0 (no response) and both interrupts are low.
- R2: A cfg_load strobe sets rem_size, rem_pkts and ep_enabled from cfg_size, cfg_pkts and cfg_en. The new values are visible on the cycle after the strobe, and bytes_sent reads 0 then.
- R3: A write is accepted when wr_valid is high, wr_len is nonzero, the endpoint is enabled, rem_size is nonzero and fewer than BUF_PKTS data packets are buffered. An accepted write lowers rem_size by wr_len, saturating at 0. A write that is not accepted leaves rem_size unchanged.
- R4: On an IN token, with the endpoint enabled, ep_nak low and a data packet buffered, tok_rsp shows 1 (data) for one cycle. That cycle is the one after the token.
- R5: An hs_ack after a data response lowers rem_pkts by one and frees that buffered packet. An hs_timeout keeps both the packet and rem_pkts, so the next token sends data again. An hs_ack with no data response outstanding changes nothing.
- R6: A write with wr_len 0 while enabled marks a zero-length packet as pending. A token with no data buffered and one pending gives tok_rsp 2 (zero-length), lowers rem_pkts by one and clears the pending mark.
- R7: A token with nothing buffered gives tok_rsp 3 (NAK). If rem_pkts is also 0 and ep_nak is low, irq_empty pulses in the same cycle as that response. With rem_pkts nonzero, irq_empty stays low.
- R8: While ep_nak is high, every token gives NAK without irq_empty and consumes nothing. A later token with ep_nak low sends the buffered packet.
- R9: While disabled, every token gives NAK without irq_empty, writes are ignored and hs_ack leaves rem_pkts unchanged.
- R10: When the endpoint is enabled with rem_size and rem_pkts both 0, irq_done pulses once on the next cycle, and ep_enabled is low from that cycle on.
- R11: bytes_sent = (loaded packet count − rem_pkts) × loaded maximum packet size. bytes_left = loaded size − bytes_sent, saturating at 0.
- R12: rem_pkts never goes below 0. An hs_ack for a packet sent while rem_pkts is 0 frees the packet and leaves rem_pkts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load strobe for a new transfer setup |
| cfg_en | input | 1 | Enable value taken on cfg_load |
| cfg_size | input | SIZE_W | Transfer length in bytes |
| cfg_pkts | input | PKT_W | Packet count |
| cfg_mps | input | LEN_W | Maximum packet size in bytes |
| ep_nak | input | 1 | Level NAK request from software |
| wr_valid | input | 1 | Software wrote one packet into the transmit buffer |
| wr_len | input | LEN_W | Byte length of that packet (0 = zero-length) |
| in_token | input | 1 | IN token received for this endpoint |
| hs_ack | input | 1 | Host acknowledged the last data packet |
| hs_timeout | input | 1 | No handshake came back after the last data packet |
| tok_rsp | output | 2 | Token answer: 0 none, 1 data, 2 zero-length, 3 NAK |
| irq_empty | output | 1 | Empty-on-token interrupt pulse |
| irq_done | output | 1 | Transfer-complete interrupt pulse |
| ep_enabled | output | 1 | Endpoint enable state |
| rem_size | output | SIZE_W | Bytes not yet written to the buffer |
| rem_pkts | output | PKT_W | Packets not yet delivered |
| bytes_sent | output | PKT_W+LEN_W | Bytes delivered on the bus |
| bytes_left | output | SIZE_W | Bytes still to deliver |

## Verification
The bench builds the block with SIZE_W=12, PKT_W=4, LEN_W=7 and BUF_PKTS=2. A two-packet buffer fills after two writes, so the rejected third write of R3 is reached in a short transfer. Small packet and size widths keep the progress arithmetic of R11, including its saturation at zero, within a few packets of 8 bytes. The zero-length second transfer and a setup with packet count 0 reach the R6, R7 and R12 corners directly.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_DATA = 2'd1,
        RSP_ZLP  = 2'd2,
        RSP_NAK  = 2'd3
    } rsp_e;

    typedef struct packed {
        logic en;
        logic nak;
        logic data_avail;
        logic zlp_pend;
        logic cnt_zero;
    } tok_ctx_t;

    function automatic rsp_e pick_rsp(input tok_ctx_t c);
        if (!c.en || c.nak)  return RSP_NAK;
        if (c.data_avail)    return RSP_DATA;
        if (c.zlp_pend)      return RSP_ZLP;
        return RSP_NAK;
    endfunction

    function automatic logic empty_hit(input tok_ctx_t c);
        return c.en && !c.nak && !c.data_avail && !c.zlp_pend && c.cnt_zero;
    endfunction

endpackage

// File: rtl/in_size_track.sv
module in_size_track #(
    parameter int SIZE_W = 19,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SIZE_W-1:0] load_size,
    input  logic              en,
    input  logic              buf_full,
    input  logic              wr_valid,
    input  logic [LEN_W-1:0]  wr_len,
    output logic [SIZE_W-1:0] rem_size,
    output logic              wr_data_acc,
    output logic              wr_zlp
);
    localparam int PAD_W = SIZE_W - LEN_W;

    logic [SIZE_W-1:0] len_ext;

    assign len_ext     = {{PAD_W{1'b0}}, wr_len};
    assign wr_data_acc = wr_valid && en && (wr_len != '0) && (rem_size != '0) && !buf_full;
    assign wr_zlp      = wr_valid && en && (wr_len == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_size <= '0;
        end else if (load) begin
            rem_size <= load_size;
        end else if (wr_data_acc) begin
            rem_size <= (len_ext >= rem_size) ? '0 : rem_size - len_ext;
        end
    end

    p_size_never_rises_r3: assert property (@(posedge clk) disable iff (rst)
        !load |=> rem_size <= $past(rem_size));

endmodule

// File: rtl/in_pkt_engine.sv
module in_pkt_engine
    import usb_in_pkg::*;
#(
    parameter int PKT_W    = 10,
    parameter int BUF_PKTS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PKT_W-1:0] load_pkts,
    input  logic             en,
    input  logic             nak,
    input  logic             wr_data_acc,
    input  logic             wr_zlp,
    input  logic             token,
    input  logic             ack,
    input  logic             tmo,
    output logic [PKT_W-1:0] rem_pkts,
    output logic             buf_full,
    output rsp_e             rsp,
    output logic             irq_empty
);
    localparam int BUF_W = $clog2(BUF_PKTS + 1);

    logic [BUF_W-1:0] buf_cnt;
    logic             zlp_pend;
    logic             awaiting;
    tok_ctx_t         ctx;
    rsp_e             rsp_next;
    logic             ack_take;
    logic             tmo_take;

    assign buf_full = (buf_cnt == BUF_W'(BUF_PKTS));
    assign ctx      = '{en: en, nak: nak, data_avail: (buf_cnt != '0),
                        zlp_pend: zlp_pend, cnt_zero: (rem_pkts == '0)};
    assign rsp_next = token ? pick_rsp(ctx) : RSP_NONE;
    assign ack_take = ack && awaiting && en;
    assign tmo_take = tmo && awaiting && en;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_pkts  <= '0;
            buf_cnt   <= '0;
            zlp_pend  <= 1'b0;
            awaiting  <= 1'b0;
            rsp       <= RSP_NONE;
            irq_empty <= 1'b0;
        end else if (load) begin
            rem_pkts  <= load_pkts;
            buf_cnt   <= '0;
            zlp_pend  <= 1'b0;
            awaiting  <= 1'b0;
            rsp       <= RSP_NONE;
            irq_empty <= 1'b0;
        end else begin
            rsp       <= rsp_next;
            irq_empty <= token && empty_hit(ctx);
            buf_cnt   <= buf_cnt + BUF_W'(wr_data_acc) - BUF_W'(ack_take);
            if (wr_zlp)
                zlp_pend <= 1'b1;
            if (rsp_next == RSP_ZLP)
                zlp_pend <= 1'b0;
            if (((rsp_next == RSP_ZLP) || ack_take) && (rem_pkts != '0))
                rem_pkts <= rem_pkts - 1'b1;
            if (ack_take || tmo_take)
                awaiting <= 1'b0;
            if (rsp_next == RSP_DATA)
                awaiting <= 1'b1;
        end
    end

    p_pkts_no_underflow_r12: assert property (@(posedge clk) disable iff (rst)
        (!load && rem_pkts == '0) |=> rem_pkts == '0);

    p_timeout_keeps_count_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && tmo && !ack && !token) |=> $stable(rem_pkts));

    p_empty_irq_with_nak_r7: assert property (@(posedge clk) disable iff (rst)
        irq_empty |-> rsp == RSP_NAK);

    p_buf_bounded_r3: assert property (@(posedge clk) disable iff (rst)
        buf_cnt <= BUF_W'(BUF_PKTS));

endmodule

// File: rtl/in_progress_calc.sv
module in_progress_calc #(
    parameter int SIZE_W = 19,
    parameter int PKT_W  = 10,
    parameter int LEN_W  = 11
) (
    input  logic [SIZE_W-1:0]      init_size,
    input  logic [PKT_W-1:0]       init_pkts,
    input  logic [PKT_W-1:0]       rem_pkts,
    input  logic [LEN_W-1:0]       mps,
    output logic [PKT_W+LEN_W-1:0] bytes_sent,
    output logic [SIZE_W-1:0]      bytes_left
);
    localparam int PROD_W = PKT_W + LEN_W;
    localparam int CMP_W  = (SIZE_W > PROD_W) ? SIZE_W : PROD_W;

    logic [PKT_W-1:0] done_pkts;
    logic [CMP_W-1:0] size_ext;
    logic [CMP_W-1:0] sent_ext;
    logic [CMP_W-1:0] diff;

    assign done_pkts  = init_pkts - rem_pkts;
    assign bytes_sent = PROD_W'(done_pkts) * PROD_W'(mps);
    assign size_ext   = CMP_W'(init_size);
    assign sent_ext   = CMP_W'(bytes_sent);
    assign diff       = size_ext - sent_ext;
    assign bytes_left = (sent_ext >= size_ext) ? '0 : diff[SIZE_W-1:0];

endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
    import usb_in_pkg::*;
#(
    parameter int SIZE_W   = 19,
    parameter int PKT_W    = 10,
    parameter int LEN_W    = 11,
    parameter int BUF_PKTS = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_load,
    input  logic                   cfg_en,
    input  logic [SIZE_W-1:0]      cfg_size,
    input  logic [PKT_W-1:0]       cfg_pkts,
    input  logic [LEN_W-1:0]       cfg_mps,
    input  logic                   ep_nak,
    input  logic                   wr_valid,
    input  logic [LEN_W-1:0]       wr_len,
    input  logic                   in_token,
    input  logic                   hs_ack,
    input  logic                   hs_timeout,
    output logic [1:0]             tok_rsp,
    output logic                   irq_empty,
    output logic                   irq_done,
    output logic                   ep_enabled,
    output logic [SIZE_W-1:0]      rem_size,
    output logic [PKT_W-1:0]       rem_pkts,
    output logic [PKT_W+LEN_W-1:0] bytes_sent,
    output logic [SIZE_W-1:0]      bytes_left
);
    logic [SIZE_W-1:0] init_size;
    logic [PKT_W-1:0]  init_pkts;
    logic [LEN_W-1:0]  mps_q;
    logic              buf_full;
    logic              wr_data_acc;
    logic              wr_zlp;
    logic              finish_now;
    rsp_e              rsp_q;

    assign tok_rsp    = rsp_q;
    assign finish_now = ep_enabled && !cfg_load && (rem_size == '0) && (rem_pkts == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ep_enabled <= 1'b0;
            irq_done   <= 1'b0;
            init_size  <= '0;
            init_pkts  <= '0;
            mps_q      <= '0;
        end else if (cfg_load) begin
            ep_enabled <= cfg_en;
            irq_done   <= 1'b0;
            init_size  <= cfg_size;
            init_pkts  <= cfg_pkts;
            mps_q      <= cfg_mps;
        end else begin
            irq_done <= finish_now;
            if (finish_now)
                ep_enabled <= 1'b0;
        end
    end

    in_size_track #(.SIZE_W(SIZE_W), .LEN_W(LEN_W)) i_size (
        .clk        (clk),
        .rst        (rst),
        .load       (cfg_load),
        .load_size  (cfg_size),
        .en         (ep_enabled),
        .buf_full   (buf_full),
        .wr_valid   (wr_valid),
        .wr_len     (wr_len),
        .rem_size   (rem_size),
        .wr_data_acc(wr_data_acc),
        .wr_zlp     (wr_zlp)
    );

    in_pkt_engine #(.PKT_W(PKT_W), .BUF_PKTS(BUF_PKTS)) i_pkt (
        .clk        (clk),
        .rst        (rst),
        .load       (cfg_load),
        .load_pkts  (cfg_pkts),
        .en         (ep_enabled),
        .nak        (ep_nak),
        .wr_data_acc(wr_data_acc),
        .wr_zlp     (wr_zlp),
        .token      (in_token),
        .ack        (hs_ack),
        .tmo        (hs_timeout),
        .rem_pkts   (rem_pkts),
        .buf_full   (buf_full),
        .rsp        (rsp_q),
        .irq_empty  (irq_empty)
    );

    in_progress_calc #(.SIZE_W(SIZE_W), .PKT_W(PKT_W), .LEN_W(LEN_W)) i_prog (
        .init_size (init_size),
        .init_pkts (init_pkts),
        .rem_pkts  (rem_pkts),
        .mps       (mps_q),
        .bytes_sent(bytes_sent),
        .bytes_left(bytes_left)
    );

    p_disabled_naks_r9: assert property (@(posedge clk) disable iff (rst)
        (in_token && !ep_enabled && !cfg_load) |=> tok_rsp == 2'd3);

    p_done_drops_enable_r10: assert property (@(posedge clk) disable iff (rst)
        irq_done |-> !ep_enabled);

    p_done_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        irq_done |=> !irq_done);

endmodule

// File: tb/test_usb_in_ep_ctrl.sv
module test_usb_in_ep_ctrl;
    localparam int SIZE_W = 12;
    localparam int PKT_W  = 4;
    localparam int LEN_W  = 7;
    localparam int BUF_PKTS = 2;

    localparam logic [1:0] K_DATA = 2'd1;
    localparam logic [1:0] K_ZLP  = 2'd2;
    localparam logic [1:0] K_NAK  = 2'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_load = 1'b0, cfg_en = 1'b0;
    logic [SIZE_W-1:0] cfg_size = '0;
    logic [PKT_W-1:0]  cfg_pkts = '0;
    logic [LEN_W-1:0]  cfg_mps = '0;
    logic ep_nak = 1'b0, wr_valid = 1'b0, in_token = 1'b0, hs_ack = 1'b0, hs_timeout = 1'b0;
    logic [LEN_W-1:0]  wr_len = '0;
    logic [1:0] tok_rsp;
    logic irq_empty, irq_done, ep_enabled;
    logic [SIZE_W-1:0] rem_size, bytes_left;
    logic [PKT_W-1:0]  rem_pkts;
    logic [PKT_W+LEN_W-1:0] bytes_sent;

    typedef struct {
        logic [1:0] kind;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    int done_cnt = 0;

    always #10 clk = ~clk;

    usb_in_ep_ctrl #(.SIZE_W(SIZE_W), .PKT_W(PKT_W), .LEN_W(LEN_W), .BUF_PKTS(BUF_PKTS)) i_usb_in_ep_ctrl (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_en(cfg_en), .cfg_size(cfg_size),
        .cfg_pkts(cfg_pkts), .cfg_mps(cfg_mps), .ep_nak(ep_nak), .wr_valid(wr_valid),
        .wr_len(wr_len), .in_token(in_token), .hs_ack(hs_ack), .hs_timeout(hs_timeout),
        .tok_rsp(tok_rsp), .irq_empty(irq_empty), .irq_done(irq_done), .ep_enabled(ep_enabled),
        .rem_size(rem_size), .rem_pkts(rem_pkts), .bytes_sent(bytes_sent), .bytes_left(bytes_left)
    );

    // monitor: pops expected token answers as the design produces them
    always @(negedge clk) begin
        if (!rst) begin
            if (irq_done) done_cnt++;
            if (tok_rsp != 2'd0 || irq_empty) begin
                n_cmp++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL unexpected response: actual rsp=%0d irq=%0d expected none", tok_rsp, irq_empty);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (tok_rsp !== e.kind || irq_empty !== e.irq) begin
                        n_bad++;
                        $display("FAIL %s: actual rsp=%0d irq=%0d expected rsp=%0d irq=%0d",
                                 e.tag, tok_rsp, irq_empty, e.kind, e.irq);
                    end
                end
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load(input logic en, input int size, input int pkts, input int mps);
        @(negedge clk);
        cfg_load = 1'b1; cfg_en = en;
        cfg_size = SIZE_W'(size); cfg_pkts = PKT_W'(pkts); cfg_mps = LEN_W'(mps);
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic write(input int len);
        @(negedge clk);
        wr_valid = 1'b1; wr_len = LEN_W'(len);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic token(input logic [1:0] kind, input logic irq, input string tag);
        exp_t e;
        e.kind = kind; e.irq = irq; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        in_token = 1'b1;
        @(negedge clk);
        in_token = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(negedge clk); hs_ack = 1'b1;
        @(negedge clk); hs_ack = 1'b0;
    endtask

    task automatic pulse_tmo();
        @(negedge clk); hs_timeout = 1'b1;
        @(negedge clk); hs_timeout = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 enabled", ep_enabled, 0);
        check("R1 rem_size", rem_size, 0);
        check("R1 rem_pkts", rem_pkts, 0);
        check("R1 rsp", tok_rsp, 0);
        check("R1 irqs", {irq_empty, irq_done}, 0);

        // main transfer: 20 bytes, 3 packets, mps 8
        load(1'b1, 20, 3, 8);
        check("R2 rem_size", rem_size, 20);
        check("R2 rem_pkts", rem_pkts, 3);
        check("R2 enabled", ep_enabled, 1);
        check("R2 bytes_sent", bytes_sent, 0);
        token(K_NAK, 1'b0, "R7 empty with packets left");
        write(8);
        check("R3 first write", rem_size, 12);
        pulse_ack();
        check("R5 stray ack ignored", rem_pkts, 3);
        write(8);
        check("R3 second write", rem_size, 4);
        write(4);
        check("R3 write when buffer full ignored", rem_size, 4);
        token(K_DATA, 1'b0, "R4 first data");
        pulse_tmo();
        check("R5 timeout keeps count", rem_pkts, 3);
        token(K_DATA, 1'b0, "R5 retransmit after timeout");
        pulse_ack();
        check("R5 ack lowers count", rem_pkts, 2);
        check("R11 bytes_sent one pkt", bytes_sent, 8);
        check("R11 bytes_left one pkt", bytes_left, 12);
        write(8);
        check("R3 saturate at zero", rem_size, 0);
        token(K_DATA, 1'b0, "R4 second data");
        pulse_ack();
        check("R10 no done while pkts left", done_cnt, 0);
        token(K_DATA, 1'b0, "R4 third data");
        pulse_ack();
        @(negedge clk);
        @(negedge clk);
        check("R10 done pulse", done_cnt, 1);
        check("R10 enable cleared", ep_enabled, 0);
        check("R11 bytes_sent all", bytes_sent, 24);
        check("R11 bytes_left saturated", bytes_left, 0);
        token(K_NAK, 1'b0, "R9 nak after completion");

        // disabled endpoint
        load(1'b0, 16, 2, 8);
        write(8);
        check("R9 write ignored while disabled", rem_size, 16);
        token(K_NAK, 1'b0, "R9 token while disabled");
        pulse_ack();
        check("R9 ack ignored while disabled", rem_pkts, 2);

        // zero-length second transfer
        load(1'b1, 0, 1, 8);
        check("R10 no done with pkt pending", ep_enabled, 1);
        write(0);
        token(K_ZLP, 1'b0, "R6 zero-length packet");
        check("R6 count lowered", rem_pkts, 0);
        @(negedge clk);
        check("R10 done after zlp", done_cnt, 2);
        check("R10 enable cleared after zlp", ep_enabled, 0);

        // packet count zero with bytes left
        load(1'b1, 10, 0, 8);
        token(K_NAK, 1'b1, "R7 empty on token interrupt");
        ep_nak = 1'b1;
        token(K_NAK, 1'b0, "R8 nak bit suppresses interrupt");
        write(5);
        check("R3 short write", rem_size, 5);
        token(K_NAK, 1'b0, "R8 nak bit holds data");
        ep_nak = 1'b0;
        token(K_DATA, 1'b0, "R8 data after nak released");
        pulse_ack();
        check("R12 count stays zero", rem_pkts, 0);
        check("R11 bytes_left with zero count", bytes_left, 10);
        token(K_NAK, 1'b1, "R12 buffer freed by ack");
        check("R10 no done with size left", done_cnt, 2);

        repeat (3) @(negedge clk);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R4 responses missing: actual %0d pending expected 0", exp_q.size());
        end
        summary();
        $finish;
    end
endmodule